// File: doc/BRIEF.md
# Burst-Aligned Stride Calculator

This unit turns a frame description (base address, pixel size, tiling mode, crop offsets, requested line stride, plane role and chroma format) into the parameters a display prefetch fetch engine needs. These are the fetch burst size, a line stride padded to whole bursts, crop offsets reduced to the micro-tile, the effective line count, the chroma-enable decision, the handshake line count and a flag that says whether the result is usable.

The request is sampled on a clock edge when `req_i` is high. All results appear together, registered, on the next cycle with a one-cycle `done_o` pulse. The results hold until the next request. Burst size follows the natural alignment of the effective start address. Tiled layouts add padding for a start that is not 8-byte aligned. An auxiliary (second) plane whose stride fits in a single burst is fetched at half height.

Top module: `bsc_stride_calc`

## Requirements
- R1: In linear mode (`mode_i` = 0), `x_off_o` and `y_off_o` are 0 and the effective address equals `base_addr_i`.
- R2: Mode 1 uses 8x8 micro-tiles. Modes 2 and 3 use micro-tiles 4 rows high that are 8 pixels wide when `fmt_i` selects 16 bpp and 4 pixels wide otherwise. In these modes X is reduced modulo the tile width and Y modulo the tile height.
- R3: `burst_o` is the value of the lowest set bit of the effective address, raised to at least 8 and capped at 128. An effective address with no set bit below bit 7, including zero, gives 128.
- R4: `fmt_i` encodes pixel bytes as 0=4, 1=3, 2=2, 3=1. In tiled modes the effective address is the base plus the reduced X times the pixel bytes.
- R5: In tiled modes `stride_o` is the requested stride, plus 8 when the effective address is not a multiple of 8, rounded up to a multiple of `burst_o`. In linear mode it is the requested stride rounded up to a multiple of `burst_o`.
- R6: When `aux_i` is set and `stride_o` <= `burst_o`, `height_o` is `height_i` halved (rounded down), the reduced Y is halved in tiled modes, and `uv_en_o` is 0. Otherwise `height_o` equals `height_i`.
- R7: `uv_en_o` is 1 only for a two-plane 4:2:0 auxiliary plane whose `stride_o` exceeds `burst_o`.
- R8: `hs8_o` is 1 (8-line handshake) when `two_plane_i` is set, and 0 (4-line) otherwise.
- R9: `valid_o` is 1 exactly when the mode is supported and `stride_o` < 0x10000.
- R10: A `mode_i` value of 4 to 7 sets `err_o`, clears `valid_o` and drives every other result field to 0.
- R11: Results and a one-cycle `done_o` pulse appear on the cycle after `req_i` is sampled high. Without a request the results hold and `done_o` stays low.
- R12: While `rst_ni` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Sample the request fields this cycle |
| base_addr_i | input | ADDR_W | Frame base address in bytes |
| fmt_i | input | 2 | Pixel size code (0=32, 1=24, 2=16, 3=8 bpp) |
| mode_i | input | 3 | Tiling mode (0 linear, 1 8x8 tiles, 2 and 3 4-row tiles) |
| x_off_i | input | DIM_W | Crop X offset in pixels |
| y_off_i | input | DIM_W | Crop Y offset in lines |
| stride_i | input | STRIDE_W | Requested line stride in bytes |
| height_i | input | DIM_W | Line count |
| aux_i | input | 1 | Auxiliary plane (1) or primary plane (0) |
| two_plane_i | input | 1 | Two-plane 4:2:0 format |
| done_o | output | 1 | Results updated this cycle |
| valid_o | output | 1 | Results usable |
| err_o | output | 1 | Unsupported tiling mode |
| burst_o | output | MAX_LOG+1 | Fetch burst size in bytes |
| stride_o | output | STRIDE_W+1 | Adjusted stride in bytes |
| x_off_o | output | DIM_W | Reduced X offset |
| y_off_o | output | DIM_W | Reduced Y offset |
| height_o | output | DIM_W | Effective line count |
| uv_en_o | output | 1 | Chroma enable for the fetch unit |
| hs8_o | output | 1 | 8-line handshake selected |

## Verification
On every cycle the assertions check the structural properties: the burst is a single power of two in range, the stride is a multiple of it, `valid_o` never accompanies an oversize stride or an error, an error zeroes the results, linear mode clears the offsets, the handshake and halving follow the sampled inputs, and results change only after a request. The exact arithmetic can only be shown by the bench's scenarios. This covers the lowest-set-bit search on the X-shifted address, the extra 8-byte padding for a misaligned tiled start, the tile width that depends on pixel size, the stride limit at exactly 0x10000, and the halving boundary where stride equals burst.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam logic [2:0] MODE_LINEAR    = 3'd0;
  localparam logic [2:0] MODE_BLOCK8    = 3'd1;
  localparam logic [2:0] MODE_GPU_TILE  = 3'd2;
  localparam logic [2:0] MODE_GPU_SUPER = 3'd3;

  typedef enum logic [1:0] {
    PX_32 = 2'd0,
    PX_24 = 2'd1,
    PX_16 = 2'd2,
    PX_8  = 2'd3
  } px_fmt_e;

  function automatic logic [2:0] px_bytes(logic [1:0] fmt);
    case (px_fmt_e'(fmt))
      PX_32:   return 3'd4;
      PX_24:   return 3'd3;
      PX_16:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/bsc_tile_geom.sv
module bsc_tile_geom
  import bsc_pkg::*;
#(
  parameter int DIM_W = 16
) (
  input  logic [2:0]       mode_i,
  input  logic [1:0]       fmt_i,
  input  logic [DIM_W-1:0] x_i,
  input  logic [DIM_W-1:0] y_i,
  output logic             tiled_o,
  output logic             err_o,
  output logic [2:0]       x_mod_o,
  output logic [2:0]       y_mod_o
);
  always_comb begin
    tiled_o = 1'b0;
    err_o   = 1'b0;
    x_mod_o = '0;
    y_mod_o = '0;
    case (mode_i)
      MODE_LINEAR: ;
      MODE_BLOCK8: begin
        tiled_o = 1'b1;
        x_mod_o = x_i[2:0];
        y_mod_o = y_i[2:0];
      end
      MODE_GPU_TILE, MODE_GPU_SUPER: begin
        tiled_o = 1'b1;
        x_mod_o = (px_fmt_e'(fmt_i) == PX_16) ? x_i[2:0] : {1'b0, x_i[1:0]};
        y_mod_o = {1'b0, y_i[1:0]};
      end
      default: err_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/bsc_burst_sel.sv
module bsc_burst_sel #(
  parameter int ADDR_W  = 32,
  parameter int MIN_LOG = 3,
  parameter int MAX_LOG = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [MAX_LOG:0]  burst_o
);
  localparam int LOG_W = $clog2(MAX_LOG + 1);

  logic [LOG_W-1:0] lsb;

  // lowest set bit; none below MAX_LOG means the cap
  always_comb begin
    lsb = LOG_W'(MAX_LOG);
    for (int i = MAX_LOG - 1; i >= 0; i--) begin
      if (addr_i[i]) lsb = LOG_W'(i);
    end
    if (lsb < LOG_W'(MIN_LOG)) lsb = LOG_W'(MIN_LOG);
  end

  assign burst_o = (MAX_LOG + 1)'(1) << lsb;
endmodule

// File: rtl/bsc_stride_pad.sv
module bsc_stride_pad #(
  parameter int STRIDE_W = 16,
  parameter int MAX_LOG  = 7,
  parameter int PAD_LOG  = 3
) (
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic                tiled_i,
  input  logic [PAD_LOG-1:0]  addr_lo_i,
  input  logic [MAX_LOG:0]    burst_i,
  output logic [STRIDE_W:0]   stride_o
);
  localparam int OW = STRIDE_W + 1;

  logic [OW-1:0] pad_add;
  logic [OW-1:0] padded;
  logic [OW-1:0] mask;
  logic [OW-1:0] sum;

  assign pad_add  = (tiled_i && (addr_lo_i != '0)) ? OW'(1 << PAD_LOG) : '0;
  assign padded   = {1'b0, stride_i} + pad_add;
  assign mask     = OW'(burst_i) - OW'(1);
  assign sum      = padded + mask;
  assign stride_o = sum & ~mask;
endmodule

// File: rtl/bsc_stride_calc.sv
module bsc_stride_calc
  import bsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DIM_W    = 16,
  parameter int STRIDE_W = 16,
  parameter int MIN_LOG  = 3,
  parameter int MAX_LOG  = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [ADDR_W-1:0]   base_addr_i,
  input  logic [1:0]          fmt_i,
  input  logic [2:0]          mode_i,
  input  logic [DIM_W-1:0]    x_off_i,
  input  logic [DIM_W-1:0]    y_off_i,
  input  logic [STRIDE_W-1:0] stride_i,
  input  logic [DIM_W-1:0]    height_i,
  input  logic                aux_i,
  input  logic                two_plane_i,
  output logic                done_o,
  output logic                valid_o,
  output logic                err_o,
  output logic [MAX_LOG:0]    burst_o,
  output logic [STRIDE_W:0]   stride_o,
  output logic [DIM_W-1:0]    x_off_o,
  output logic [DIM_W-1:0]    y_off_o,
  output logic [DIM_W-1:0]    height_o,
  output logic                uv_en_o,
  output logic                hs8_o
);
  localparam int          OW    = STRIDE_W + 1;
  localparam logic [OW-1:0] LIMIT = OW'(1) << STRIDE_W;

  logic              tiled, bad_mode;
  logic [2:0]        x_mod, y_mod;
  logic [ADDR_W-1:0] eff_addr;
  logic [MAX_LOG:0]  burst;
  logic [OW-1:0]     stride_adj;
  logic              halve;
  logic [2:0]        y_fin;
  logic [DIM_W-1:0]  h_fin;
  logic              uv_fin;

  bsc_tile_geom #(.DIM_W(DIM_W)) i_geom (
    .mode_i  (mode_i),
    .fmt_i   (fmt_i),
    .x_i     (x_off_i),
    .y_i     (y_off_i),
    .tiled_o (tiled),
    .err_o   (bad_mode),
    .x_mod_o (x_mod),
    .y_mod_o (y_mod)
  );

  // x_mod is zero in linear mode, so this collapses to the base
  assign eff_addr = base_addr_i + ADDR_W'(x_mod * px_bytes(fmt_i));

  bsc_burst_sel #(
    .ADDR_W (ADDR_W),
    .MIN_LOG(MIN_LOG),
    .MAX_LOG(MAX_LOG)
  ) i_burst (
    .addr_i (eff_addr),
    .burst_o(burst)
  );

  bsc_stride_pad #(
    .STRIDE_W(STRIDE_W),
    .MAX_LOG (MAX_LOG),
    .PAD_LOG (3)
  ) i_pad (
    .stride_i (stride_i),
    .tiled_i  (tiled),
    .addr_lo_i(eff_addr[2:0]),
    .burst_i  (burst),
    .stride_o (stride_adj)
  );

  assign halve  = aux_i && (stride_adj <= OW'(burst));
  assign y_fin  = halve ? (y_mod >> 1) : y_mod;
  assign h_fin  = halve ? (height_i >> 1) : height_i;
  assign uv_fin = two_plane_i && aux_i && !halve;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
      burst_o  <= '0;
      stride_o <= '0;
      x_off_o  <= '0;
      y_off_o  <= '0;
      height_o <= '0;
      uv_en_o  <= 1'b0;
      hs8_o    <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        if (bad_mode) begin
          valid_o  <= 1'b0;
          err_o    <= 1'b1;
          burst_o  <= '0;
          stride_o <= '0;
          x_off_o  <= '0;
          y_off_o  <= '0;
          height_o <= '0;
          uv_en_o  <= 1'b0;
          hs8_o    <= 1'b0;
        end else begin
          valid_o  <= stride_adj < LIMIT;
          err_o    <= 1'b0;
          burst_o  <= burst;
          stride_o <= stride_adj;
          x_off_o  <= DIM_W'(x_mod);
          y_off_o  <= DIM_W'(y_fin);
          height_o <= h_fin;
          uv_en_o  <= uv_fin;
          hs8_o    <= two_plane_i;
        end
      end
    end
  end
endmodule

// File: rtl/bsc_stride_calc_chk.sv
module bsc_stride_calc_chk #(
  parameter int ADDR_W   = 32,
  parameter int DIM_W    = 16,
  parameter int STRIDE_W = 16,
  parameter int MIN_LOG  = 3,
  parameter int MAX_LOG  = 7
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic [ADDR_W-1:0]   base_addr_i,
  input logic [1:0]          fmt_i,
  input logic [2:0]          mode_i,
  input logic [DIM_W-1:0]    x_off_i,
  input logic [DIM_W-1:0]    y_off_i,
  input logic [STRIDE_W-1:0] stride_i,
  input logic [DIM_W-1:0]    height_i,
  input logic                aux_i,
  input logic                two_plane_i,
  input logic                done_o,
  input logic                valid_o,
  input logic                err_o,
  input logic [MAX_LOG:0]    burst_o,
  input logic [STRIDE_W:0]   stride_o,
  input logic [DIM_W-1:0]    x_off_o,
  input logic [DIM_W-1:0]    y_off_o,
  input logic [DIM_W-1:0]    height_o,
  input logic                uv_en_o,
  input logic                hs8_o
);
  localparam int OW = STRIDE_W + 1;

  p_lin_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ($past(mode_i) == 3'd0) |-> (x_off_o == '0) && (y_off_o == '0));

  p_burst_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> ($countones(burst_o) == 1) &&
      (burst_o >= (MAX_LOG + 1)'(1 << MIN_LOG)));

  p_stride_mult_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> ((stride_o & (OW'(burst_o) - OW'(1))) == '0) &&
      (stride_o >= OW'($past(stride_i))));

  p_halve_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o && $past(aux_i) && (stride_o <= OW'(burst_o)) |->
      !uv_en_o && (height_o == ($past(height_i) >> 1)));

  p_uv_cond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_en_o |-> hs8_o && !err_o && (stride_o > OW'(burst_o)));

  p_hs8_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> hs8_o == $past(two_plane_i));

  p_valid_lim_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !err_o && (stride_o < (OW'(1) << STRIDE_W)));

  p_err_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !valid_o && (stride_o == '0) && (burst_o == '0) && !uv_en_o);

  p_done_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(req_i));

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(req_i) |-> !done_o && $stable(stride_o) && $stable(burst_o) && $stable(height_o));
endmodule

bind bsc_stride_calc bsc_stride_calc_chk #(
  .ADDR_W  (ADDR_W),
  .DIM_W   (DIM_W),
  .STRIDE_W(STRIDE_W),
  .MIN_LOG (MIN_LOG),
  .MAX_LOG (MAX_LOG)
) i_chk (.*);

// File: tb/test_bsc_stride_calc.sv
module test_bsc_stride_calc;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] base_addr_i = '0;
  logic [1:0]  fmt_i = '0;
  logic [2:0]  mode_i = '0;
  logic [15:0] x_off_i = '0, y_off_i = '0, stride_i = '0, height_i = '0;
  logic        aux_i = 1'b0, two_plane_i = 1'b0;
  logic        done_o, valid_o, err_o, uv_en_o, hs8_o;
  logic [7:0]  burst_o;
  logic [16:0] stride_o;
  logic [15:0] x_off_o, y_off_o, height_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  bsc_stride_calc i_bsc_stride_calc (.*);

  typedef struct packed {
    logic [2:0]  mode;
    logic [1:0]  fmt;
    logic [31:0] base;
    logic [15:0] x;
    logic [15:0] y;
    logic [15:0] stride;
    logic [15:0] h;
    logic        aux;
    logic        tp;
    logic [7:0]  e_burst;
    logic [16:0] e_stride;
    logic [15:0] e_x;
    logic [15:0] e_y;
    logic [15:0] e_h;
    logic        e_uv;
    logic        e_hs8;
    logic        e_valid;
    logic        e_err;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 32'h1000_0040, 16'd5,  16'd3,  16'd1000,   16'd480, 1'b0, 1'b0, 8'd64,  17'd1024,    16'd0, 16'd0, 16'd480, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd1, 2'd3, 32'h2000_0000, 16'd13, 16'd10, 16'd640,    16'd720, 1'b0, 1'b1, 8'd8,   17'd648,     16'd5, 16'd2, 16'd720, 1'b0, 1'b1, 1'b1, 1'b0},
    '{3'd2, 2'd2, 32'h0000_0100, 16'd11, 16'd7,  16'd300,    16'd100, 1'b0, 1'b0, 8'd8,   17'd312,     16'd3, 16'd3, 16'd100, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd3, 2'd0, 32'h0000_0080, 16'd6,  16'd5,  16'd256,    16'd64,  1'b0, 1'b0, 8'd8,   17'd256,     16'd2, 16'd1, 16'd64,  1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd1, 2'd3, 32'h0000_0400, 16'd8,  16'd6,  16'd100,    16'd50,  1'b1, 1'b1, 8'd128, 17'd128,     16'd0, 16'd3, 16'd25,  1'b0, 1'b1, 1'b1, 1'b0},
    '{3'd0, 2'd0, 32'h0000_0040, 16'd3,  16'd3,  16'd200,    16'd200, 1'b1, 1'b1, 8'd64,  17'd256,     16'd0, 16'd0, 16'd200, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd0, 2'd1, 32'h0000_0000, 16'd0,  16'd0,  16'd1,      16'd10,  1'b0, 1'b0, 8'd128, 17'd128,     16'd0, 16'd0, 16'd10,  1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd0, 2'd0, 32'h0000_0080, 16'd0,  16'd0,  16'hFFF0,   16'd8,   1'b0, 1'b0, 8'd128, 17'h10000,   16'd0, 16'd0, 16'd8,   1'b0, 1'b0, 1'b0, 1'b0},
    '{3'd0, 2'd0, 32'h0000_0080, 16'd0,  16'd0,  16'hFF80,   16'd8,   1'b0, 1'b0, 8'd128, 17'h0FF80,   16'd0, 16'd0, 16'd8,   1'b0, 1'b0, 1'b1, 1'b0},
    '{3'd5, 2'd0, 32'h0000_0040, 16'd3,  16'd3,  16'd100,    16'd20,  1'b1, 1'b1, 8'd0,   17'd0,       16'd0, 16'd0, 16'd0,   1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd0, 2'd0, 32'h0000_0100, 16'd4,  16'd5,  16'd64,     16'd31,  1'b1, 1'b1, 8'd128, 17'd128,     16'd0, 16'd0, 16'd15,  1'b0, 1'b1, 1'b1, 1'b0},
    '{3'd2, 2'd1, 32'h0000_1000, 16'd7,  16'd2,  16'd96,     16'd40,  1'b1, 1'b1, 8'd8,   17'd104,     16'd3, 16'd2, 16'd40,  1'b1, 1'b1, 1'b1, 1'b0},
    '{3'd1, 2'd2, 32'h0000_0018, 16'd4,  16'd5,  16'd20,     16'd9,   1'b1, 1'b0, 8'd32,  17'd32,      16'd4, 16'd2, 16'd4,   1'b0, 1'b0, 1'b1, 1'b0}
  };

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic check_zero(string tag);
    chk(tag, "done", done_o, 0);
    chk(tag, "valid", valid_o, 0);
    chk(tag, "err", err_o, 0);
    chk(tag, "burst", burst_o, 0);
    chk(tag, "stride", stride_o, 0);
    chk(tag, "height", height_o, 0);
    chk(tag, "uv", uv_en_o, 0);
    chk(tag, "hs8", hs8_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [16:0] held;
    repeat (3) @(negedge clk_i);
    check_zero("R12");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int k = 0; k < NV; k++) begin
      mode_i      = VEC[k].mode;
      fmt_i       = VEC[k].fmt;
      base_addr_i = VEC[k].base;
      x_off_i     = VEC[k].x;
      y_off_i     = VEC[k].y;
      stride_i    = VEC[k].stride;
      height_i    = VEC[k].h;
      aux_i       = VEC[k].aux;
      two_plane_i = VEC[k].tp;
      req_i       = 1'b1;
      @(negedge clk_i);
      req_i = 1'b0;
      chk("R11", "done", done_o, 1);
      chk("R3/R4", "burst", burst_o, VEC[k].e_burst);
      chk("R5", "stride", stride_o, VEC[k].e_stride);
      chk("R1/R2", "x", x_off_o, VEC[k].e_x);
      chk("R1/R2/R6", "y", y_off_o, VEC[k].e_y);
      chk("R6", "height", height_o, VEC[k].e_h);
      chk("R7", "uv", uv_en_o, VEC[k].e_uv);
      chk("R8", "hs8", hs8_o, VEC[k].e_hs8);
      chk("R9", "valid", valid_o, VEC[k].e_valid);
      chk("R10", "err", err_o, VEC[k].e_err);
    end

    // R11: inputs change without a request, results must hold
    held = stride_o;
    mode_i   = 3'd0;
    stride_i = 16'd5000;
    base_addr_i = 32'h1;
    height_i = 16'd777;
    repeat (3) @(negedge clk_i);
    chk("R11", "done idle", done_o, 0);
    chk("R11", "stride hold", stride_o, held);
    chk("R11", "height hold", height_o, 16'd4);

    // R3: odd base in linear mode gives the minimum burst
    base_addr_i = 32'h0000_0003;
    stride_i    = 16'd17;
    aux_i       = 1'b0;
    two_plane_i = 1'b0;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R3", "burst min", burst_o, 8);
    chk("R5", "stride min", stride_o, 24);
    @(negedge clk_i);
    chk("R11", "done pulse", done_o, 0);

    // R12: asynchronous reset clears the results
    #(CLK_PERIOD / 4) rst_ni = 1'b0;
    #(CLK_PERIOD / 8);
    check_zero("R12");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule